// File: doc/BRIEF.md
# Self-Refresh Entry and Exit Sequencer

This block sits on the controller side of a DRAM interface. It moves the memory into its low-power self-refresh state and brings it back out. A power manager asks for entry and exit with two request pulses. The clock generator reports through a single level when the memory clock has settled. The block drives the clock-enable pin and a small command selector (refresh, NOP, or deselect). It also gives the main command scheduler two permission flags: one for ordinary commands and one for READ commands.

Entry is a refresh command with clock-enable low in the same cycle. The block then holds clock-enable low and deselects the device. After an exit request, the block waits for a stable clock before it raises clock-enable. It then enforces two separate counted windows. A short NOP-only window must elapse before any command is allowed. A longer delay lets the device's internal delay-locked loop relock before reads are allowed. A parameter selects a conservative policy that keeps every command blocked for the full long delay.

Top module: `sr_seq_top`

## Requirements
- R1: After reset the block is idle with `cke` = 1, `cmd` = NOP (2'b01), and both `cmd_ready` and `read_ready` = 1.
- R2: An `enter_req` sampled while idle, with `refresh_busy` low, produces in the next cycle exactly one cycle of `cmd` = REFRESH (2'b10) together with `cke` = 0, and both ready flags drop.
- R3: An `enter_req` sampled while `refresh_busy` is high is ignored: outputs keep their idle values.
- R4: While in self refresh, `cke` stays 0, `cmd` is DESELECT (2'b00), both ready flags are 0, and further `enter_req` pulses have no effect.
- R5: An `exit_req` in self refresh starts the exit, but `cke` rises only in the cycle after `clk_stable` is sampled high. With `clk_stable` low, `cke` stays 0 indefinitely.
- R6: In the default policy, from the first cycle with `cke` high, `cmd` is NOP and `cmd_ready` is 0 for exactly XSNR_CYCLES cycles, and then `cmd_ready` is 1.
- R7: From the first cycle with `cke` high, `read_ready` is 0 for exactly DLL_CYCLES cycles, and then 1. `cmd_ready` may be 1 earlier.
- R8: With CONSERVATIVE = 1, `cmd_ready` is 0 for exactly DLL_CYCLES cycles after `cke` rises.
- R9: `exit_req` outside self refresh (while idle or during the entry cycle) is ignored.
- R10: After the exit completes the block returns to idle and accepts a new entry request.
- R11: `read_ready` is never 1 while `cmd_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enter_req | input | 1 | Power manager asks for self-refresh entry |
| exit_req | input | 1 | Power manager asks for self-refresh exit |
| clk_stable | input | 1 | Memory clock has settled |
| refresh_busy | input | 1 | A scheduler-issued refresh is still running |
| cke | output | 1 | Clock-enable pin to the DRAM |
| cmd | output | 2 | Command selector: 00 deselect, 01 NOP, 10 refresh |
| cmd_ready | output | 1 | Non-read commands may be issued |
| read_ready | output | 1 | READ commands may be issued |

## Verification
Two things can fall in the same cycle while idle: a power manager's entry request and a refresh still in progress. The bench drives both in one cycle and then checks that the outputs keep their idle values. A second pairing is an exit request that arrives while the clock is already stable, against one that arrives while it is not. The bench runs both and judges the rise of `cke` against the cycle in which `clk_stable` was sampled. It also counts the cycles in which each ready flag stays low after the rise, and compares those counts with the two window lengths.

// File: rtl/sr_seq_pkg.sv
package sr_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_ENTER    = 3'd1,
      ST_IN_SR    = 3'd2,
      ST_WAIT_CLK = 3'd3,
      ST_EXIT_NOP = 3'd4,
      ST_READY    = 3'd5
   } sr_state_t;

   typedef enum logic [1:0] {
      CMD_DESEL = 2'b00,
      CMD_NOP   = 2'b01,
      CMD_REF   = 2'b10
   } sr_cmd_t;

endpackage

// File: rtl/sr_seq_timer.sv
module sr_seq_timer #(
   parameter int unsigned LOAD_VAL = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic en,
   output logic done
);
   localparam int unsigned CW = $clog2(LOAD_VAL + 1);

   logic [CW-1:0] count_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (load) begin
         count_q <= CW'(LOAD_VAL);
      end else if (en && (count_q != '0)) begin
         count_q <= count_q - 1'b1;
      end
   end

   assign done = (count_q == '0);

   AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !load && !done) |=> (count_q == $past(count_q) - 1'b1)); // R6

   AST_TMR_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && done) |=> done); // R7

endmodule

// File: rtl/sr_seq_fsm.sv
module sr_seq_fsm
   import sr_seq_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      enter_req,
   input  logic      exit_req,
   input  logic      clk_stable,
   input  logic      refresh_busy,
   input  logic      dll_done,
   output sr_state_t state,
   output logic      timers_load
);
   sr_state_t state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:     if (enter_req && !refresh_busy) state_d = ST_ENTER;
         ST_ENTER:    state_d = ST_IN_SR;
         ST_IN_SR:    if (exit_req) state_d = ST_WAIT_CLK;
         ST_WAIT_CLK: if (clk_stable) state_d = ST_EXIT_NOP;
         ST_EXIT_NOP: if (dll_done) state_d = ST_READY;
         ST_READY:    state_d = ST_IDLE;
         default:     state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign timers_load = (state_q == ST_WAIT_CLK) && clk_stable;
   assign state       = state_q;

   AST_ENTRY_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && refresh_busy) |=> (state_q == ST_IDLE)); // R3

   AST_SR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IN_SR && !exit_req) |=> (state_q == ST_IN_SR)); // R4

   AST_EXIT_IGNORED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && !enter_req) |=> (state_q == ST_IDLE)); // R9

endmodule

// File: rtl/sr_seq_outdec.sv
module sr_seq_outdec
   import sr_seq_pkg::*;
#(
   parameter bit CONSERVATIVE = 1'b0
) (
   input  sr_state_t state,
   input  logic      xsnr_done,
   input  logic      dll_done,
   output logic      cke,
   output logic [1:0] cmd,
   output logic      cmd_ready,
   output logic      read_ready
);
   logic any_done;

   generate
      if (CONSERVATIVE) begin : g_cons
         assign any_done = dll_done;
      end else begin : g_fast
         assign any_done = xsnr_done;
      end
   endgenerate

   always_comb begin
      cke        = 1'b1;
      cmd        = CMD_NOP;
      cmd_ready  = 1'b1;
      read_ready = 1'b1;
      unique case (state)
         ST_ENTER: begin
            cke = 1'b0; cmd = CMD_REF; cmd_ready = 1'b0; read_ready = 1'b0;
         end
         ST_IN_SR, ST_WAIT_CLK: begin
            cke = 1'b0; cmd = CMD_DESEL; cmd_ready = 1'b0; read_ready = 1'b0;
         end
         ST_EXIT_NOP: begin
            cmd_ready  = any_done;
            read_ready = dll_done;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/sr_seq_top.sv
module sr_seq_top
   import sr_seq_pkg::*;
#(
   parameter int unsigned XSNR_CYCLES  = 10,
   parameter int unsigned DLL_CYCLES   = 200,
   parameter bit          CONSERVATIVE = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       enter_req,
   input  logic       exit_req,
   input  logic       clk_stable,
   input  logic       refresh_busy,
   output logic       cke,
   output logic [1:0] cmd,
   output logic       cmd_ready,
   output logic       read_ready
);
   generate
      if (XSNR_CYCLES < 1) begin : g_bad_xsnr
         $error("XSNR_CYCLES must be at least 1");
      end
      if (DLL_CYCLES < XSNR_CYCLES) begin : g_bad_dll
         $error("DLL_CYCLES must not be shorter than XSNR_CYCLES");
      end
   endgenerate

   sr_state_t state;
   logic      timers_load;
   logic      xsnr_done, dll_done;
   logic      in_exit;

   assign in_exit = (state == ST_EXIT_NOP);

   sr_seq_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .enter_req    (enter_req),
      .exit_req     (exit_req),
      .clk_stable   (clk_stable),
      .refresh_busy (refresh_busy),
      .dll_done     (dll_done),
      .state        (state),
      .timers_load  (timers_load)
   );

   sr_seq_timer #(.LOAD_VAL(XSNR_CYCLES)) u_xsnr_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (timers_load),
      .en    (in_exit),
      .done  (xsnr_done)
   );

   sr_seq_timer #(.LOAD_VAL(DLL_CYCLES)) u_dll_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (timers_load),
      .en    (in_exit),
      .done  (dll_done)
   );

   sr_seq_outdec #(.CONSERVATIVE(CONSERVATIVE)) u_outdec (
      .state      (state),
      .xsnr_done  (xsnr_done),
      .dll_done   (dll_done),
      .cke        (cke),
      .cmd        (cmd),
      .cmd_ready  (cmd_ready),
      .read_ready (read_ready)
   );

   AST_CKE_NEEDS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cke) |-> $past(clk_stable)); // R5

   AST_ENTRY_IS_REF: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cke) |-> (cmd == CMD_REF)); // R2

   AST_LOW_CKE_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke && !$fell(cke)) |-> (cmd == CMD_DESEL && !cmd_ready)); // R4

   AST_NOP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      (cke && !cmd_ready) |-> (cmd == CMD_NOP)); // R6

   AST_READ_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      read_ready |-> cmd_ready); // R11

endmodule

// File: tb/sr_seq_top_tb.sv
module sr_seq_top_tb_top;
   localparam int unsigned XS = 10;
   localparam int unsigned DL = 200;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enter_req = 1'b0, exit_req = 1'b0, clk_stable = 1'b0, refresh_busy = 1'b0;
   logic       cke, cr, rr, cke_c, cr_c, rr_c;
   logic [1:0] cmd, cmd_c;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   sr_seq_top #(.XSNR_CYCLES(XS), .DLL_CYCLES(DL), .CONSERVATIVE(1'b0)) dut_i (
      .clk(clk), .rst_n(rst_n), .enter_req(enter_req), .exit_req(exit_req),
      .clk_stable(clk_stable), .refresh_busy(refresh_busy),
      .cke(cke), .cmd(cmd), .cmd_ready(cr), .read_ready(rr));

   sr_seq_top #(.XSNR_CYCLES(XS), .DLL_CYCLES(DL), .CONSERVATIVE(1'b1)) dut_c (
      .clk(clk), .rst_n(rst_n), .enter_req(enter_req), .exit_req(exit_req),
      .clk_stable(clk_stable), .refresh_busy(refresh_busy),
      .cke(cke_c), .cmd(cmd_c), .cmd_ready(cr_c), .read_ready(rr_c));

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic chk_outs(input string tag, input int ek, input int ec, input int er, input int erd);
      chk({tag, " cke"}, cke, ek);
      chk({tag, " cmd"}, cmd, ec);
      chk({tag, " cmd_ready"}, cr, er);
      chk({tag, " read_ready"}, rr, erd);
   endtask

   task automatic t_reset();
      chk_outs("R1 reset", 1, 1, 1, 1);
      chk("R1 reset cons cke", cke_c, 1);
   endtask

   task automatic t_busy_enter();
      enter_req = 1'b1; refresh_busy = 1'b1;
      @(negedge clk);
      enter_req = 1'b0; refresh_busy = 1'b0;
      chk_outs("R3 enter while busy", 1, 1, 1, 1);
      @(negedge clk);
      chk_outs("R3 enter while busy later", 1, 1, 1, 1);
   endtask

   task automatic t_exit_idle();
      clk_stable = 1'b1; exit_req = 1'b1;
      @(negedge clk);
      exit_req = 1'b0;
      chk_outs("R9 exit in idle", 1, 1, 1, 1);
      @(negedge clk);
      chk_outs("R9 exit in idle later", 1, 1, 1, 1);
   endtask

   task automatic t_enter();
      enter_req = 1'b1;
      @(negedge clk);
      enter_req = 1'b0;
      chk_outs("R2 entry cycle", 0, 2, 0, 0);
      exit_req = 1'b1;
      @(negedge clk);
      exit_req = 1'b0;
      chk_outs("R4 in self refresh", 0, 0, 0, 0);
      enter_req = 1'b1;
      @(negedge clk);
      enter_req = 1'b0;
      for (int i = 0; i < 3; i++) begin
         chk_outs("R9 R4 exit during entry ignored", 0, 0, 0, 0);
         @(negedge clk);
      end
   endtask

   task automatic t_exit(input bit stable_first);
      int ncr, nrr, ncrc, guard;
      clk_stable = stable_first;
      exit_req = 1'b1;
      @(negedge clk);
      exit_req = 1'b0;
      chk_outs("R5 waiting for clock", 0, 0, 0, 0);
      if (!stable_first) begin
         for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R5 cke low without stable clock", cke, 0);
         end
         clk_stable = 1'b1;
      end
      @(negedge clk);
      chk("R5 cke rises after stable clock", cke, 1);
      chk("R5 cons cke rises", cke_c, 1);
      ncr = 0; nrr = 0; ncrc = 0; guard = 0;
      while ((!rr || !rr_c) && guard < DL + 20) begin
         if (!cr) begin
            ncr++;
            chk("R6 only NOP in window", cmd, 1);
         end
         if (!rr) nrr++;
         if (!cr_c) ncrc++;
         if (rr && !cr) chk("R11 read without cmd ready", 0, 1);
         guard++;
         @(negedge clk);
      end
      chk("R6 cmd_ready low cycles", ncr, XS);
      chk("R7 read_ready low cycles", nrr, DL);
      chk("R8 conservative cmd_ready low cycles", ncrc, DL);
      @(negedge clk);
      @(negedge clk);
      chk_outs("R10 back to idle", 1, 1, 1, 1);
   endtask

   task automatic t_reenter();
      enter_req = 1'b1;
      @(negedge clk);
      enter_req = 1'b0;
      chk_outs("R10 re-entry accepted", 0, 2, 0, 0);
      @(negedge clk);
      chk_outs("R10 R4 in self refresh again", 0, 0, 0, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_busy_enter();
      t_exit_idle();
      t_enter();
      t_exit(1'b0);
      t_reenter();
      t_exit(1'b1);
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule